// File: doc/BRIEF.md
# Carrier Board Management Controller

This block is the control logic for a carrier board that hosts a processor module. It steers a JTAG port from the USB bridge toward the module or parks it so the carrier's own configuration port can be reached. It raises the module power enable and then the mezzanine rail enable after timed delays that start when reset is released. It drives an active-low module reset from a debounced push button. It also picks the processor boot source, sets the adjustable rail's voltage-select code, and connects the UART lines between the bridge and the module.

All routing, boot-select, voltage-select and UART paths are combinational. The power sequencer and the reset controller are registered on one clock and use an asynchronous active-low global reset. All delays are parameters: `PWR_DLY`, `MEZZ_DLY`, `DEB_CYC` and `HOLD_CYC`.

Top module: `cbm_top`

## Requirements
- R1: With `sw_jtag_n`=0, `mod_tck`/`mod_tms`/`mod_tdi` follow `host_tck`/`host_tms`/`host_tdi` and `host_tdo` follows `mod_tdo`.
- R2: With `sw_jtag_n`=1, the module port is parked at `mod_tck`=0, `mod_tms`=1, `mod_tdi`=0, and `host_tdo` is 1, whatever the host drives.
- R3: `cpld_upd_mode` is 1 exactly when `sw_jtag_n`=0 and `sw_m1`=1 and `sw_m2`=1.
- R4: `vsel` is 3'b001 (the 1.8 V code) while `cpld_upd_mode`=1. Otherwise it carries parameter `VSEL_DEF`, which defaults to 3'b010.
- R5: Counting the first rising clock edge after `rst_n` rises as edge 1, `mod_pwr_en` is 0 through edge `PWR_DLY`-1 and is 1 from edge `PWR_DLY` on.
- R6: `mezz_pwr_en` is 0 through edge `PWR_DLY`+`MEZZ_DLY`-1 and is 1 from edge `PWR_DLY`+`MEZZ_DLY` on.
- R7: Driving `rst_n` low clears `mod_pwr_en`, `mezz_pwr_en` and `mod_rst_n` at once, with no clock edge needed.
- R8: `mod_rst_n` stays 0 through edge `PWR_DLY`+`HOLD_CYC` and becomes 1 at edge `PWR_DLY`+`HOLD_CYC`+1.
- R9: If `btn_rst` (1 = pressed) changes and then holds steady, counting the first edge after the change as edge 1, `mod_rst_n` takes the new level (low while pressed) at edge `DEB_CYC`+3 and not before.
- R10: A `btn_rst` pulse much shorter than `DEB_CYC` clocks leaves `mod_rst_n` high.
- R11: `boot_sd` equals `sd_present`: 1 selects SD boot and 0 selects flash boot.
- R12: `mod_uart_rx` follows `bridge_rx`, and `bridge_tx` follows `mod_uart_tx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| sw_jtag_n | input | 1 | JTAG routing switch; 0 = to module, 1 = carrier configuration access |
| sw_m1 | input | 1 | Mode switch 1 |
| sw_m2 | input | 1 | Mode switch 2 |
| host_tck | input | 1 | Upstream TCK |
| host_tms | input | 1 | Upstream TMS |
| host_tdi | input | 1 | Upstream TDI |
| host_tdo | output | 1 | Upstream TDO |
| mod_tck | output | 1 | Module TCK |
| mod_tms | output | 1 | Module TMS |
| mod_tdi | output | 1 | Module TDI |
| mod_tdo | input | 1 | Module TDO |
| cpld_upd_mode | output | 1 | Module-CPLD update mode select |
| btn_rst | input | 1 | Reset push button, 1 = pressed, asynchronous |
| sd_present | input | 1 | SD card present |
| boot_sd | output | 1 | Boot source, 1 = SD, 0 = flash |
| vsel | output | 3 | Adjustable rail voltage-select code |
| mod_pwr_en | output | 1 | Module power enable |
| mezz_pwr_en | output | 1 | Mezzanine rail enable |
| mod_rst_n | output | 1 | Active-low module reset |
| bridge_rx | input | 1 | UART receive line from the bridge |
| mod_uart_rx | output | 1 | UART receive line to the module |
| mod_uart_tx | input | 1 | UART transmit line from the module |
| bridge_tx | output | 1 | UART transmit line to the bridge |

## Verification
The assertions assume that the switch inputs and `sd_present` are static or change only between clock edges. They also assume that `rst_n` is released away from a clock edge, so that the sequencer's edge count starts cleanly. The bench changes every input a couple of nanoseconds after a rising edge and samples outputs in the same quiet window. The bench also shortens the delay parameters so the full power-up order and the button timing fit in a short run, while the edge arithmetic stays the same as with the default values.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
    typedef enum logic [1:0] {
        PS_WAIT_MOD  = 2'd0,
        PS_WAIT_MEZZ = 2'd1,
        PS_ON        = 2'd2
    } pwr_phase_e;

    localparam logic [2:0] VSEL_1V8 = 3'b001;
endpackage

// File: rtl/cbm_jtag_route.sv
module cbm_jtag_route (
    input  logic sw_jtag_n,
    input  logic sw_m1,
    input  logic sw_m2,
    input  logic host_tck,
    input  logic host_tms,
    input  logic host_tdi,
    output logic host_tdo,
    output logic mod_tck,
    output logic mod_tms,
    output logic mod_tdi,
    input  logic mod_tdo,
    output logic cpld_mode
);
    logic to_module;

    always_comb begin
        to_module = ~sw_jtag_n;
        if (to_module) begin
            mod_tck  = host_tck;
            mod_tms  = host_tms;
            mod_tdi  = host_tdi;
            host_tdo = mod_tdo;
        end else begin
            // park the module TAP: clock low, TMS high keeps it in reset
            mod_tck  = 1'b0;
            mod_tms  = 1'b1;
            mod_tdi  = 1'b0;
            host_tdo = 1'b1;
        end
        cpld_mode = to_module & sw_m1 & sw_m2;
    end
endmodule

// File: rtl/cbm_power_seq.sv
module cbm_power_seq
    import cbm_pkg::*;
#(
    parameter int PWR_DLY  = 65536,
    parameter int MEZZ_DLY = 65536
) (
    input  logic clk,
    input  logic rst_n,
    output logic mod_en,
    output logic mezz_en
);
    localparam int MAXD = (PWR_DLY > MEZZ_DLY) ? PWR_DLY : MEZZ_DLY;
    localparam int CW   = $clog2(MAXD + 1);
    localparam logic [CW-1:0] MOD_LAST  = CW'(PWR_DLY - 1);
    localparam logic [CW-1:0] MEZZ_LAST = CW'(MEZZ_DLY - 1);

    typedef struct packed {
        pwr_phase_e    phase;
        logic [CW-1:0] cnt;
        logic          mod_en;
        logic          mezz_en;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.phase)
            PS_WAIT_MOD: begin
                if (seq_q.cnt == MOD_LAST) begin
                    seq_d.phase  = PS_WAIT_MEZZ;
                    seq_d.cnt    = '0;
                    seq_d.mod_en = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            PS_WAIT_MEZZ: begin
                if (seq_q.cnt == MEZZ_LAST) begin
                    seq_d.phase   = PS_ON;
                    seq_d.cnt     = '0;
                    seq_d.mezz_en = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.cnt = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{phase: PS_WAIT_MOD, cnt: '0, mod_en: 1'b0, mezz_en: 1'b0};
        else        seq_q <= seq_d;
    end

    assign mod_en  = seq_q.mod_en;
    assign mezz_en = seq_q.mezz_en;

    // R6
    mezz_after_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mezz_en |-> mod_en);

    // R5
    mod_en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mod_en |=> mod_en);

    // R6
    mezz_rise_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mezz_en) |-> $past(seq_q.phase) == PS_WAIT_MEZZ);
endmodule

// File: rtl/cbm_reset_ctl.sv
module cbm_reset_ctl #(
    parameter int DEB_CYC  = 16384,
    parameter int HOLD_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn,
    input  logic pwr_ok,
    output logic mod_rst_n
);
    localparam int DW = $clog2(DEB_CYC + 1);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [DW-1:0] DEB_LAST  = DW'(DEB_CYC - 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          stable;
        logic [DW-1:0] dcnt;
        logic [HW-1:0] hcnt;
        logic          hold_done;
        logic          rst_n_out;
    } rc_t;

    rc_t rc_d, rc_q;

    always_comb begin
        rc_d      = rc_q;
        rc_d.sync = {rc_q.sync[0], btn};
        if (rc_q.sync[1] != rc_q.stable) begin
            if (rc_q.dcnt == DEB_LAST) begin
                rc_d.stable = rc_q.sync[1];
                rc_d.dcnt   = '0;
            end else begin
                rc_d.dcnt = rc_q.dcnt + 1'b1;
            end
        end else begin
            rc_d.dcnt = '0;
        end
        if (pwr_ok && !rc_q.hold_done) begin
            if (rc_q.hcnt == HOLD_LAST) rc_d.hold_done = 1'b1;
            else                        rc_d.hcnt      = rc_q.hcnt + 1'b1;
        end
        rc_d.rst_n_out = rc_q.hold_done & ~rc_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rc_q <= '0;
        else        rc_q <= rc_d;
    end

    assign mod_rst_n = rc_q.rst_n_out;

    // R8
    rst_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mod_rst_n |-> pwr_ok);

    // R9
    deb_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rc_q.stable) |-> rc_q.stable == $past(rc_q.sync[1]));
endmodule

// File: rtl/cbm_top.sv
module cbm_top
    import cbm_pkg::*;
#(
    parameter int         PWR_DLY  = 65536,
    parameter int         MEZZ_DLY = 65536,
    parameter int         DEB_CYC  = 16384,
    parameter int         HOLD_CYC = 1024,
    parameter logic [2:0] VSEL_DEF = 3'b010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_jtag_n,
    input  logic       sw_m1,
    input  logic       sw_m2,
    input  logic       host_tck,
    input  logic       host_tms,
    input  logic       host_tdi,
    output logic       host_tdo,
    output logic       mod_tck,
    output logic       mod_tms,
    output logic       mod_tdi,
    input  logic       mod_tdo,
    output logic       cpld_upd_mode,
    input  logic       btn_rst,
    input  logic       sd_present,
    output logic       boot_sd,
    output logic [2:0] vsel,
    output logic       mod_pwr_en,
    output logic       mezz_pwr_en,
    output logic       mod_rst_n,
    input  logic       bridge_rx,
    output logic       mod_uart_rx,
    input  logic       mod_uart_tx,
    output logic       bridge_tx
);
    logic cpld_mode;

    cbm_jtag_route u_jtag (
        .sw_jtag_n (sw_jtag_n),
        .sw_m1     (sw_m1),
        .sw_m2     (sw_m2),
        .host_tck  (host_tck),
        .host_tms  (host_tms),
        .host_tdi  (host_tdi),
        .host_tdo  (host_tdo),
        .mod_tck   (mod_tck),
        .mod_tms   (mod_tms),
        .mod_tdi   (mod_tdi),
        .mod_tdo   (mod_tdo),
        .cpld_mode (cpld_mode)
    );

    cbm_power_seq #(.PWR_DLY(PWR_DLY), .MEZZ_DLY(MEZZ_DLY)) u_pwr (
        .clk     (clk),
        .rst_n   (rst_n),
        .mod_en  (mod_pwr_en),
        .mezz_en (mezz_pwr_en)
    );

    cbm_reset_ctl #(.DEB_CYC(DEB_CYC), .HOLD_CYC(HOLD_CYC)) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .btn       (btn_rst),
        .pwr_ok    (mod_pwr_en),
        .mod_rst_n (mod_rst_n)
    );

    assign cpld_upd_mode = cpld_mode;
    assign vsel          = cpld_mode ? VSEL_1V8 : VSEL_DEF;
    assign boot_sd       = sd_present;
    assign mod_uart_rx   = bridge_rx;
    assign bridge_tx     = mod_uart_tx;

    // R4
    cpld_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpld_upd_mode |-> vsel == VSEL_1V8);

    // R2
    park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_jtag_n |-> (!mod_tck && mod_tms && !cpld_upd_mode));

    // R1
    pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_jtag_n |-> (mod_tck == host_tck && host_tdo == mod_tdo));
endmodule

// File: tb/cbm_top_test.sv
module cbm_top_test;
    localparam int P = 32;
    localparam int M = 24;
    localparam int D = 16;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_jtag_n = 1'b0, sw_m1 = 1'b0, sw_m2 = 1'b0;
    logic host_tck = 1'b0, host_tms = 1'b0, host_tdi = 1'b0, mod_tdo = 1'b0;
    logic btn_rst = 1'b0, sd_present = 1'b0, bridge_rx = 1'b0, mod_uart_tx = 1'b0;
    logic host_tdo, mod_tck, mod_tms, mod_tdi, cpld_upd_mode, boot_sd;
    logic mod_pwr_en, mezz_pwr_en, mod_rst_n, mod_uart_rx, bridge_tx;
    logic [2:0] vsel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cbm_top #(.PWR_DLY(P), .MEZZ_DLY(M), .DEB_CYC(D), .HOLD_CYC(H)) uut (
        .clk(clk), .rst_n(rst_n), .sw_jtag_n(sw_jtag_n), .sw_m1(sw_m1), .sw_m2(sw_m2),
        .host_tck(host_tck), .host_tms(host_tms), .host_tdi(host_tdi), .host_tdo(host_tdo),
        .mod_tck(mod_tck), .mod_tms(mod_tms), .mod_tdi(mod_tdi), .mod_tdo(mod_tdo),
        .cpld_upd_mode(cpld_upd_mode), .btn_rst(btn_rst), .sd_present(sd_present),
        .boot_sd(boot_sd), .vsel(vsel), .mod_pwr_en(mod_pwr_en), .mezz_pwr_en(mezz_pwr_en),
        .mod_rst_n(mod_rst_n), .bridge_rx(bridge_rx), .mod_uart_rx(mod_uart_rx),
        .mod_uart_tx(mod_uart_tx), .bridge_tx(bridge_tx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // inputs: jtag_n m1 m2 sd tck tms tdi mtdo brx mtx
    // expect: mtck mtms mtdi htdo cpld vsel[2:0] boot mrx btx
    localparam logic [20:0] VEC [6] = '{
        {10'b0000101010, 11'b10100_010_010},
        {10'b0111010101, 11'b01011_001_101},
        {10'b1110111011, 11'b01010_010_011},
        {10'b0101111100, 11'b11110_010_100},
        {10'b1001101001, 11'b01010_010_101},
        {10'b0010000011, 11'b00000_010_011}
    };

    initial begin
        #150000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        edges(3);
        check("R7 reset state pwr", {30'd0, mod_pwr_en, mezz_pwr_en}, 0);
        check("R7 reset state rst", mod_rst_n, 0);
        rst_n = 1'b1;
        // R5 / R6 / R8 timing from reset release
        edges(P - 1);
        check("R5 mod_en low before delay", mod_pwr_en, 0);
        edges(1);
        check("R5 mod_en high at delay", mod_pwr_en, 1);
        check("R8 rst held low", mod_rst_n, 0);
        edges(H);
        check("R8 rst still low at hold end", mod_rst_n, 0);
        edges(1);
        check("R8 rst released after hold", mod_rst_n, 1);
        edges(M - H - 2);
        check("R6 mezz low before delay", mezz_pwr_en, 0);
        edges(1);
        check("R6 mezz high at delay", mezz_pwr_en, 1);

        // R1 R2 R3 R4 R11 R12 vector table
        for (int i = 0; i < 6; i++) begin
            {sw_jtag_n, sw_m1, sw_m2, sd_present, host_tck, host_tms, host_tdi,
             mod_tdo, bridge_rx, mod_uart_tx} = VEC[i][20:11];
            edges(1);
            check("R1 R2 jtag", {mod_tck, mod_tms, mod_tdi, host_tdo}, VEC[i][10:7]);
            check("R3 cpld mode", cpld_upd_mode, VEC[i][6]);
            check("R4 vsel", vsel, VEC[i][5:3]);
            check("R11 boot", boot_sd, VEC[i][2]);
            check("R12 uart", {mod_uart_rx, bridge_tx}, VEC[i][1:0]);
        end

        // R10 short glitch ignored
        btn_rst = 1'b1;
        edges(4);
        btn_rst = 1'b0;
        begin
            int lows = 0;
            for (int k = 0; k < 3 * D; k++) begin
                edges(1);
                if (!mod_rst_n) lows++;
            end
            check("R10 glitch ignored", lows, 0);
        end

        // R9 long press then release
        btn_rst = 1'b1;
        edges(D + 2);
        check("R9 press not yet seen", mod_rst_n, 1);
        edges(1);
        check("R9 press asserts reset", mod_rst_n, 0);
        edges(5);
        btn_rst = 1'b0;
        edges(D + 2);
        check("R9 release not yet seen", mod_rst_n, 0);
        edges(1);
        check("R9 release deasserts reset", mod_rst_n, 1);

        // R7 asynchronous clear
        #1 rst_n = 1'b0;
        #1;
        check("R7 async clear enables", {30'd0, mod_pwr_en, mezz_pwr_en}, 0);
        check("R7 async clear reset out", mod_rst_n, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule